// File: doc/BRIEF.md
# Cascaded Priority Match Address Driver

This block drives the 16-bit active-address output of one device in a daisy chain of content-addressable memories. The value is a 4-bit page field above a 12-bit address. A register keeps whatever address the latest operation produced. The sources are a plain operation (next free, CAM read, CAM write, table read, table write) or a comparison. A comparison has three possible outcomes: a CAM hit, a table hit, or a total miss.

After a comparison, the block uses the chain position to decide whether this device may drive the shared bus. The device that drives a CAM hit is the one whose upstream match flag shows no earlier match. A table hit or a total miss is driven only by the device configured as last in the chain. The last device drives all ones on a total miss, and it does not drive if any device upstream reported a CAM hit. Any device that is not the chosen driver keeps its drive enable low, whatever the state of output enable. High impedance is not modelled with internal tristates: it is signalled by a drive-enable output placed beside the value.

Control is a five-state machine:
- ST_IDLE: the state after reset.
- ST_HELD: a plain source was loaded.
- ST_CAM: a comparison hit in the CAM.
- ST_TBL: the CAM missed and the enabled table hit.
- ST_MISS: no usable hit.

Any valid operation with a defined code moves the machine to the state for that operation, from any state. Undefined codes and cycles with no operation keep the current state.

Top module: `cascade_addr_driver`

## Requirements
- R1: While `rst_n` is low and after reset:
  - the state is ST_IDLE;
  - `act_drive` is 0;
  - `act_addr` is 0;
  - the local match flag is clear, so `mf_dn_n` follows `mf_up_n`.
- R2: A valid operation with `op_src` 1 (next free), 2 (CAM read), 3 (CAM write), 4 (table read) or 5 (table write) has these effects:
  - it loads `op_addr` into the held address, and the value appears on `act_addr` in the cycle after the clock edge;
  - it moves the machine to ST_HELD;
  - in ST_HELD, `act_drive` equals `oe`.
- R3: A valid comparison (`op_src` 0) with `cam_hit` high has these effects:
  - it loads `cam_addr` and enters ST_CAM;
  - the device then drives when `oe` is high and `mf_up_n` is high.
- R4: In ST_CAM, a low `mf_up_n` (an earlier device matched) forces `act_drive` low even when `oe` is high.
- R5: A comparison with a CAM miss, `tbl_hit` high and `tbl_dis` low has these effects:
  - it loads `tbl_addr` and enters ST_TBL;
  - the device then drives only when `cfg_last`, `mf_up_n` and `oe` are all high.
- R6: A comparison with a CAM miss and either no table hit or `tbl_dis` high has these effects:
  - it enters ST_MISS with `act_addr` all ones;
  - the device then drives only when `cfg_last`, `mf_up_n` and `oe` are all high.
- R7: In ST_TBL or ST_MISS, a device with `cfg_last` low never drives, whatever the state of `oe`.
- R8: `mf_dn_n` is low when `mf_up_n` is low or the most recent comparison hit in the local CAM. The local flag is kept across plain operations.
- R9: A cycle with `op_valid` low, or with `op_src` 6 or 7, leaves the state, the held address and the local flag unchanged.
- R10: With `oe` low, `act_drive` is 0 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_src | input | 3 | Operation code: 0 compare, 1 to 5 plain sources |
| op_addr | input | 16 | Address produced by a plain operation |
| cam_hit | input | 1 | Local CAM match result of the comparison |
| cam_addr | input | 16 | Local highest-priority CAM match address |
| tbl_hit | input | 1 | Table match result of the comparison |
| tbl_addr | input | 16 | Table match address |
| tbl_dis | input | 1 | Table disabled for this comparison |
| cfg_last | input | 1 | This device is last (lowest priority) in the chain |
| mf_up_n | input | 1 | Upstream match flag, active low; high on the first device |
| oe | input | 1 | Output enable |
| act_addr | output | 16 | Active address value |
| act_drive | output | 1 | Bus drive enable; low means high impedance |
| mf_dn_n | output | 1 | Downstream match flag, active low |

## Verification
The bench attacks four corner cases.

The first is a CAM hit while an upstream device already matched. A design that ignored the chain would drive two devices onto the bus at once.

The second is a table hit or a total miss on a device that is not last, with output enable high. A wrong design would drive a stale or all-ones address from the middle of the chain. The bench also checks that the last device stays quiet when an upstream CAM hit was reported.

The third is a comparison with the table disabled. A design that ignored the disable would return the table address instead of all ones.

The fourth is undefined operation codes and the keeping of the local match flag across plain reads and writes. A design that got this wrong would corrupt the held address, or would release the downstream flag early.

// File: rtl/cad_pkg.sv
package cad_pkg;

    localparam int SRC_W = 3;

    localparam logic [SRC_W-1:0] SRC_CMP    = 3'd0;
    localparam logic [SRC_W-1:0] SRC_FREE   = 3'd1;
    localparam logic [SRC_W-1:0] SRC_CAM_RD = 3'd2;
    localparam logic [SRC_W-1:0] SRC_CAM_WR = 3'd3;
    localparam logic [SRC_W-1:0] SRC_TBL_RD = 3'd4;
    localparam logic [SRC_W-1:0] SRC_TBL_WR = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HELD = 3'd1,
        ST_CAM  = 3'd2,
        ST_TBL  = 3'd3,
        ST_MISS = 3'd4
    } drv_st_e;

    function automatic logic is_plain(input logic [SRC_W-1:0] s);
        return (s >= SRC_FREE) && (s <= SRC_TBL_WR);
    endfunction

endpackage

// File: rtl/cad_fsm.sv
module cad_fsm
    import cad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [SRC_W-1:0] op_src,
    input  logic             cam_hit,
    input  logic             tbl_hit,
    input  logic             tbl_dis,
    output drv_st_e          cur_st
);

    drv_st_e nxt_st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= ST_IDLE;
        end else begin
            cur_st <= nxt_st;
        end
    end

    always_comb begin
        nxt_st = cur_st;
        if (op_valid) begin
            if (op_src == SRC_CMP) begin
                if (cam_hit) begin
                    nxt_st = ST_CAM;
                end else if (tbl_hit && !tbl_dis) begin
                    nxt_st = ST_TBL;
                end else begin
                    nxt_st = ST_MISS;
                end
            end else if (is_plain(op_src)) begin
                nxt_st = ST_HELD;
            end
        end
    end

endmodule

// File: rtl/cad_hold.sv
module cad_hold
    import cad_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [SRC_W-1:0] op_src,
    input  logic [BUS_W-1:0] op_addr,
    input  logic             cam_hit,
    input  logic [BUS_W-1:0] cam_addr,
    input  logic             tbl_hit,
    input  logic [BUS_W-1:0] tbl_addr,
    input  logic             tbl_dis,
    output logic [BUS_W-1:0] held_addr
);

    localparam logic [BUS_W-1:0] ALL_ONES = {BUS_W{1'b1}};

    logic [BUS_W-1:0] nxt_addr;

    always_comb begin
        nxt_addr = held_addr;
        if (op_valid) begin
            if (op_src == SRC_CMP) begin
                if (cam_hit) begin
                    nxt_addr = cam_addr;
                end else if (tbl_hit && !tbl_dis) begin
                    nxt_addr = tbl_addr;
                end else begin
                    nxt_addr = ALL_ONES;
                end
            end else if (is_plain(op_src)) begin
                nxt_addr = op_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
        end else begin
            held_addr <= nxt_addr;
        end
    end

endmodule

// File: rtl/cad_chain.sv
module cad_chain
    import cad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [SRC_W-1:0] op_src,
    input  logic             cam_hit,
    input  logic             mf_up_n,
    output logic             loc_hit,
    output logic             mf_dn_n
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_hit <= 1'b0;
        end else if (op_valid && (op_src == SRC_CMP)) begin
            loc_hit <= cam_hit;
        end
    end

    assign mf_dn_n = mf_up_n & ~loc_hit;

endmodule

// File: rtl/cascade_addr_driver.sv
module cascade_addr_driver
    import cad_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [2:0]               op_src,
    input  logic [PAGE_W+ADDR_W-1:0] op_addr,
    input  logic                     cam_hit,
    input  logic [PAGE_W+ADDR_W-1:0] cam_addr,
    input  logic                     tbl_hit,
    input  logic [PAGE_W+ADDR_W-1:0] tbl_addr,
    input  logic                     tbl_dis,
    input  logic                     cfg_last,
    input  logic                     mf_up_n,
    input  logic                     oe,
    output logic [PAGE_W+ADDR_W-1:0] act_addr,
    output logic                     act_drive,
    output logic                     mf_dn_n
);

    localparam int BUS_W = PAGE_W + ADDR_W;

    drv_st_e          cur_st;
    logic [BUS_W-1:0] held_addr;
    logic             loc_hit;

    cad_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_src   (op_src),
        .cam_hit  (cam_hit),
        .tbl_hit  (tbl_hit),
        .tbl_dis  (tbl_dis),
        .cur_st   (cur_st)
    );

    cad_hold #(.BUS_W(BUS_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_src    (op_src),
        .op_addr   (op_addr),
        .cam_hit   (cam_hit),
        .cam_addr  (cam_addr),
        .tbl_hit   (tbl_hit),
        .tbl_addr  (tbl_addr),
        .tbl_dis   (tbl_dis),
        .held_addr (held_addr)
    );

    cad_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_src   (op_src),
        .cam_hit  (cam_hit),
        .mf_up_n  (mf_up_n),
        .loc_hit  (loc_hit),
        .mf_dn_n  (mf_dn_n)
    );

    // Output decode: the chain position gates the drive after a comparison.
    always_comb begin
        act_addr  = held_addr;
        act_drive = 1'b0;
        unique case (cur_st)
            ST_IDLE: act_drive = 1'b0;
            ST_HELD: act_drive = oe;
            ST_CAM:  act_drive = oe & mf_up_n & loc_hit;
            ST_TBL:  act_drive = oe & mf_up_n & cfg_last;
            ST_MISS: act_drive = oe & mf_up_n & cfg_last;
            default: act_drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/cad_checker.sv
module cad_checker
    import cad_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_src,
    input logic             cam_hit,
    input logic [BUS_W-1:0] cam_addr,
    input logic             cfg_last,
    input logic             mf_up_n,
    input logic             oe,
    input logic [BUS_W-1:0] act_addr,
    input logic             act_drive,
    input logic             mf_dn_n,
    input drv_st_e          cur_st
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !act_drive);

    p_upstream_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_CAM) && !mf_up_n |-> !act_drive);

    p_nonlast_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_st == ST_TBL) || (cur_st == ST_MISS)) && !cfg_last |-> !act_drive);

    p_miss_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_MISS) |-> (act_addr == {BUS_W{1'b1}}));

    p_chain_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_up_n |-> !mf_dn_n);

    p_cam_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_valid && (op_src == SRC_CMP) && cam_hit)
        |-> (act_addr == $past(cam_addr)) && !mf_dn_n);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(!op_valid) |-> $stable(act_addr));

endmodule

bind cascade_addr_driver cad_checker #(.BUS_W(PAGE_W + ADDR_W)) chk_i (.*);

// File: tb/cascade_addr_driver_tb_top.sv
`timescale 1ns/1ps
module cascade_addr_driver_tb_top;

    localparam int BW = 16;
    localparam logic [BW-1:0] ONES = 16'hFFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [2:0]    op_src = 3'd0;
    logic [BW-1:0] op_addr = '0;
    logic          cam_hit = 1'b0;
    logic [BW-1:0] cam_addr = '0;
    logic          tbl_hit = 1'b0;
    logic [BW-1:0] tbl_addr = '0;
    logic          tbl_dis = 1'b0;
    logic          cfg_last = 1'b0;
    logic          mf_up_n = 1'b1;
    logic          oe = 1'b0;
    logic [BW-1:0] act_addr;
    logic          act_drive;
    logic          mf_dn_n;

    always #2.5 clk = ~clk;

    cascade_addr_driver dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_src(op_src),
        .op_addr(op_addr), .cam_hit(cam_hit), .cam_addr(cam_addr),
        .tbl_hit(tbl_hit), .tbl_addr(tbl_addr), .tbl_dis(tbl_dis),
        .cfg_last(cfg_last), .mf_up_n(mf_up_n), .oe(oe),
        .act_addr(act_addr), .act_drive(act_drive), .mf_dn_n(mf_dn_n)
    );

    // Reference model kinds: 0 idle, 1 held, 2 cam, 3 table, 4 miss
    int            m_kind = 0;
    logic [BW-1:0] m_addr = '0;
    bit            m_hit  = 1'b0;
    int            n_cmp  = 0;
    int            n_bad  = 0;
    bit            started = 1'b0;
    bit            done = 1'b0;
    string         force_tag = "";

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_kind = 0; m_addr = '0; m_hit = 1'b0;
        end else if (op_valid) begin
            if (op_src == 3'd0) begin
                m_hit = cam_hit;
                if (cam_hit) begin
                    m_kind = 2; m_addr = cam_addr;
                end else if (tbl_hit && !tbl_dis) begin
                    m_kind = 3; m_addr = tbl_addr;
                end else begin
                    m_kind = 4; m_addr = ONES;
                end
            end else if (op_src >= 3'd1 && op_src <= 3'd5) begin
                m_kind = 1; m_addr = op_addr;
            end
        end
    end

    function automatic string auto_tag();
        if (force_tag != "") return force_tag;
        if (!rst_n || m_kind == 0) return "R1";
        if (!oe) return "R10";
        case (m_kind)
            1: return "R2";
            2: return mf_up_n ? "R3" : "R4";
            3: return cfg_last ? "R5" : "R7";
            default: return cfg_last ? "R6" : "R7";
        endcase
    endfunction

    always @(negedge clk) begin
        if (started && !done) begin
            bit exp_drv;
            bit exp_mf;
            string t;
            t = auto_tag();
            case (m_kind)
                1: exp_drv = oe;
                2: exp_drv = oe && mf_up_n;
                3, 4: exp_drv = oe && mf_up_n && cfg_last;
                default: exp_drv = 1'b0;
            endcase
            exp_mf = mf_up_n && !m_hit;
            n_cmp++;
            if (act_drive !== exp_drv) begin
                n_bad++;
                $display("FAIL %s drive: actual %0b expected %0b", t, act_drive, exp_drv);
            end
            n_cmp++;
            if (act_addr !== m_addr) begin
                n_bad++;
                $display("FAIL %s addr: actual %h expected %h", t, act_addr, m_addr);
            end
            n_cmp++;
            if (mf_dn_n !== exp_mf) begin
                n_bad++;
                $display("FAIL R8 (%s) flag: actual %0b expected %0b", t, mf_dn_n, exp_mf);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_op(input logic [2:0] s, input logic [BW-1:0] a,
                         input logic ch, input logic [BW-1:0] ca,
                         input logic th, input logic [BW-1:0] ta, input logic td);
        op_valid = 1'b1; op_src = s; op_addr = a;
        cam_hit = ch; cam_addr = ca; tbl_hit = th; tbl_addr = ta; tbl_dis = td;
        tick();
        op_valid = 1'b0;
        tick();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lf;
        force_tag = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        force_tag = "";
        oe = 1'b1; mf_up_n = 1'b1; cfg_last = 1'b0;
        // R2: every plain source code
        for (int s = 1; s <= 5; s++) do_op(3'(s), 16'h1230 + 16'(s), 0, 0, 0, 0, 0);
        // R10: enable low
        oe = 1'b0; tick(); tick(); oe = 1'b1;
        // R3 then R4
        do_op(3'd0, 0, 1, 16'h2ABC, 1, 16'h0555, 0);
        mf_up_n = 1'b0; tick(); tick(); mf_up_n = 1'b1;
        // R8: flag kept across plain op
        do_op(3'd2, 16'h0777, 0, 0, 0, 0, 0);
        // R7 / R5: table hit, middle then last device
        do_op(3'd0, 0, 0, 16'h1111, 1, 16'h3456, 0);
        cfg_last = 1'b1; tick();
        mf_up_n = 1'b0; tick(); mf_up_n = 1'b1;
        // R6: total miss, then table disabled
        do_op(3'd0, 0, 0, 0, 0, 16'h4444, 0);
        do_op(3'd0, 0, 0, 0, 1, 16'h4444, 1);
        cfg_last = 1'b0; tick();
        // R9: undefined codes and idle garbage
        force_tag = "R9";
        do_op(3'd6, 16'hAAAA, 1, 16'hBBBB, 0, 0, 0);
        do_op(3'd7, 16'hCCCC, 0, 0, 1, 16'hDDDD, 0);
        op_src = 3'd0; cam_hit = 1'b1; cam_addr = 16'h9999; tick(); tick();
        force_tag = "";
        // Mixed pseudo-random phase
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            op_valid = lf[0]; op_src = lf[3:1] % 3'd7; op_addr = lf[19:4];
            cam_hit = lf[5]; cam_addr = lf[27:12]; tbl_hit = lf[7];
            tbl_addr = lf[31:16]; tbl_dis = lf[9] & lf[10];
            cfg_last = lf[11]; mf_up_n = lf[13] | lf[14]; oe = lf[15] | lf[2];
            tick();
        end
        op_valid = 1'b0;
        tick();
        finish_run();
    end

endmodule